// File: doc/BRIEF.md
# Autovectored Shared Interrupt Controller

This block gathers fourteen peripheral interrupt sources onto a single interrupt line for an 8-bit microcontroller core. A one-cycle pulse on a source input sets that source's pending latch. A pending source only takes part in interrupt generation when firmware has set its enable bit. A main flag drives the interrupt output. It rises when the set of enabled, pending sources goes from empty to non-empty. It also rises again right after firmware clears a pending latch while other enabled sources are still waiting.

The clear rules differ between the two kinds of flag. Pending latches are cleared by writing a 1 to their bit. The main flag is cleared by writing a 0 to it. A vector byte names the lowest-numbered enabled pending source as that index times four.

The block also watches the core's code-fetch path. The interrupt entry point is a three-byte long jump at 0x0053–0x0055. When autovectoring is on, the byte fetched from 0x0055 is replaced by the vector byte. The shared interrupt then lands directly on a per-source entry in a jump table that has a 4-byte stride.

Top module: `autovec_irq_ctrl`

## Requirements
- R1: After reset the enables, pending latches, main flag and autovector enable all read zero, `irq` is low and `vec_byte` is 0.
- R2: Register address 0 holds the enable mask in bits 13:0. It reads back what was written. Bits 15:14 read zero.
- R3: A pulse on `src_pulse[i]` sets pending bit i of address 1, whatever the enable state. The bit is visible after the clock edge that samples the pulse.
- R4: Writing address 1 clears each pending bit written as 1. Bits written as 0 keep their value.
- R5: If bit i is pulsed in the same cycle that firmware writes 1 to pending bit i, the bit stays set.
- R6: The main flag (address 2, bit 0) is set on the edge after the set of enabled pending sources becomes non-empty. A pulse sampled at edge k therefore raises `irq` at edge k+1. `irq` always equals the main flag.
- R7: Writing 0 to address 2 bit 0 clears the main flag. Writing 1 there has no effect.
- R8: After any write to address 1, if an enabled source is still pending, the main flag is set on the next edge.
- R9: If the main flag is already set when a write to address 1 leaves another source pending, nothing extra is recorded. A later firmware clear of the main flag then leaves `irq` low while that source stays pending.
- R10: The vector byte equals 4 × the index of the lowest-numbered enabled pending source, or 0 when there is none. It appears on `vec_byte` and in bits 15:8 of address 3.
- R11: Address 3 bit 0 is the autovector enable. When it is 1, a fetch from code address 0x0055 returns the vector byte on `code_data`.
- R12: For any other code address, or when autovectoring is off, `code_data` equals `code_mem_data`. This includes 0x0053 and 0x0054.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 enable, 1 pending, 2 main flag, 3 config/vector) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| src_pulse | input | 14 | One-cycle request pulses from the peripherals |
| code_addr | input | 16 | Core code-fetch address |
| code_mem_data | input | 8 | Byte returned by code memory |
| code_data | output | 8 | Byte delivered to the core |
| vec_byte | output | 8 | Current vector byte |
| irq | output | 1 | Shared interrupt to the core |

## Verification
The assertions assume that a source pulse and a register write only change between clock edges. They also assume that `reg_addr` is stable while `reg_we` is high. The bench meets this by driving every input on the falling edge. It holds a write for exactly one cycle and reads only while the strobe is low. The priority checks assume that the vector fits in 8 bits. The sweep stays inside that range by using only the fourteen real source indices.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned NUM_SRC     = 14;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned VEC_W       = 8;
  localparam int unsigned STRIDE_LOG2 = 2;
  localparam int unsigned CODE_AW     = 16;
  localparam logic [CODE_AW-1:0] SUB_ADDR = 16'h0055;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PEND   = 2'd1,
    SEL_MAIN   = 2'd2,
    SEL_CFG    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isc_req_bank.sv
module isc_req_bank #(
  parameter int unsigned N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_pulse,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] en_d;
  logic [N-1:0] pend_d;

  always_comb en_d = en_we ? wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_latch
    always_comb pend_d[i] = src_pulse[i] | (pend_q[i] & ~(clr_we & wdata[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end

  assert_pulse_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((wdata & src_pulse) != '0)) |=> ((pend_q & $past(wdata & src_pulse)) != '0));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((wdata & ~src_pulse) != '0)) |=> ((pend_q & $past(wdata & ~src_pulse)) == '0));

  assert_untouched_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((pend_q ^ $past(pend_q)) & ~$past(src_pulse | (clr_we ? wdata : '0))) == '0));
endmodule

// File: rtl/isc_main_flag.sv
module isc_main_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic rearm,
  input  logic main_we,
  input  logic main_wbit,
  output logic main_q
);
  logic seen_q, seen_d;
  logic set_evt;
  logic main_d;

  always_comb begin
    set_evt = any_pend & ~seen_q;
    seen_d  = rearm ? 1'b0 : any_pend;
    if (set_evt)                    main_d = 1'b1;
    else if (main_we && !main_wbit) main_d = 1'b0;
    else                            main_d = main_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      main_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      main_q <= main_d;
    end
  end

  assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_pend) |=> main_q);

  assert_rearm_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rearm) && any_pend |=> main_q);

  assert_write0_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (main_we && !main_wbit && !(any_pend && !seen_q)) |=> !main_q);

  assert_write1_noset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_q && !any_pend) |=> !main_q);
endmodule

// File: rtl/isc_vec_enc.sv
module isc_vec_enc #(
  parameter int unsigned N           = 14,
  parameter int unsigned VW          = 8,
  parameter int unsigned STRIDE_LOG2 = 2
) (
  input  logic [N-1:0]  pend_en,
  output logic [VW-1:0] vec
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_en[i]) idx = IDX_W'(i);
    end
    vec = VW'(idx) << STRIDE_LOG2;
  end
endmodule

// File: rtl/isc_fetch_mux.sv
module isc_fetch_mux #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] HIT_ADDR = '0
) (
  input  logic          av_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    mem_byte,
  input  logic [7:0]    vec,
  output logic [7:0]    out_byte
);
  logic hit;

  always_comb begin
    hit      = av_en && (addr == HIT_ADDR);
    out_byte = hit ? vec : mem_byte;
  end
endmodule

// File: rtl/autovec_irq_ctrl.sv
module autovec_irq_ctrl
  import isc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0]  src_pulse,
  input  logic [CODE_AW-1:0]  code_addr,
  input  logic [7:0]          code_mem_data,
  output logic [7:0]          code_data,
  output logic [VEC_W-1:0]    vec_byte,
  output logic                irq
);
  logic [NUM_SRC-1:0] en_q, pend_q, pend_en;
  logic               en_we, clr_we, main_we, cfg_we;
  logic               main_q;
  logic               av_en_q, av_en_d;
  logic               any_pend;
  logic               unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_SRC];

  always_comb begin
    en_we   = reg_we && (reg_sel_e'(reg_addr) == SEL_ENABLE);
    clr_we  = reg_we && (reg_sel_e'(reg_addr) == SEL_PEND);
    main_we = reg_we && (reg_sel_e'(reg_addr) == SEL_MAIN);
    cfg_we  = reg_we && (reg_sel_e'(reg_addr) == SEL_CFG);
    av_en_d = cfg_we ? reg_wdata[0] : av_en_q;
    pend_en = pend_q & en_q;
    any_pend = |pend_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) av_en_q <= 1'b0;
    else        av_en_q <= av_en_d;
  end

  isc_req_bank #(.N(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .en_we(en_we), .clr_we(clr_we), .wdata(reg_wdata[NUM_SRC-1:0]),
    .en_q(en_q), .pend_q(pend_q)
  );

  isc_main_flag u_main (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .rearm(clr_we),
    .main_we(main_we), .main_wbit(reg_wdata[0]), .main_q(main_q)
  );

  isc_vec_enc #(.N(NUM_SRC), .VW(VEC_W), .STRIDE_LOG2(STRIDE_LOG2)) u_enc (
    .pend_en(pend_en), .vec(vec_byte)
  );

  isc_fetch_mux #(.AW(CODE_AW), .HIT_ADDR(SUB_ADDR)) u_fetch (
    .av_en(av_en_q), .addr(code_addr), .mem_byte(code_mem_data),
    .vec(vec_byte), .out_byte(code_data)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      SEL_ENABLE: reg_rdata = DATA_W'(en_q);
      SEL_PEND:   reg_rdata = DATA_W'(pend_q);
      SEL_MAIN:   reg_rdata = DATA_W'(main_q);
      SEL_CFG:    reg_rdata = {vec_byte, 7'd0, av_en_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = main_q;

  logic [NUM_SRC-1:0] chk_hit, chk_below;
  always_comb begin
    chk_hit   = pend_en >> (vec_byte >> STRIDE_LOG2);
    chk_below = pend_en & ((NUM_SRC'(1) << (vec_byte >> STRIDE_LOG2)) - NUM_SRC'(1));
  end

  assert_vec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_en == '0) |-> (vec_byte == '0));

  assert_vec_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_en != '0) |-> (chk_hit[0] && (chk_below == '0)));

  assert_fetch_sub_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (av_en_q && code_addr == SUB_ADDR) |-> (code_data == vec_byte));

  assert_fetch_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!av_en_q || code_addr != SUB_ADDR) |-> (code_data == code_mem_data));
endmodule

// File: tb/autovec_irq_ctrl_bench.sv
module autovec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [13:0] src_pulse = 14'd0;
  logic [15:0] code_addr = 16'd0;
  logic [7:0]  code_mem_data = 8'd0;
  logic [7:0]  code_data;
  logic [7:0]  vec_byte;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autovec_irq_ctrl u_autovec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
    .code_addr(code_addr), .code_mem_data(code_mem_data), .code_data(code_data),
    .vec_byte(vec_byte), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [13:0] s);
    @(negedge clk);
    src_pulse = s;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_vec(input logic [13:0] p);
    for (int i = 0; i < 14; i++) if (p[i]) return 8'(i * 4);
    return 8'd0;
  endfunction

  task automatic cleanup();
    wr(2'd1, 16'h3FFF);
    wr(2'd2, 16'h0000);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [13:0] lfsr;
    logic [13:0] pat, ena;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); check("R1", d, 0); end
    check("R1 irq", irq, 0);
    check("R1 vec", vec_byte, 0);
    code_addr = 16'h0055; code_mem_data = 8'h77; #1;
    check("R1 fetch", code_data, 8'h77);

    // R2 enable register
    wr(2'd0, 16'h2A5A); rd(2'd0, d); check("R2", d, 16'h2A5A);
    wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R2 top bits", d, 16'h3FFF);

    // R3, R6, R10, R4: single-source sweep
    for (int i = 0; i < 14; i++) begin
      pulse(14'(1 << i));
      rd(2'd1, d); check("R3", d, 16'(1 << i));
      check("R10 single", vec_byte, 8'(i * 4));
      check("R6 not yet", irq, 0);
      idle(1);
      check("R6 irq", irq, 1);
      rd(2'd2, d); check("R6 flag reg", d, 1);
      wr(2'd1, 16'h0000); rd(2'd1, d); check("R4 w0 keeps", d, 16'(1 << i));
      wr(2'd1, 16'(1 << i)); rd(2'd1, d); check("R4 w1 clears", d, 0);
      wr(2'd2, 16'h0001); check("R7 w1 no effect", irq, 1);
      wr(2'd2, 16'h0000); check("R7 w0 clears", irq, 0);
    end

    // R3 sets latch even when disabled; R10 ignores disabled sources
    wr(2'd0, 16'h0000);
    pulse(14'h0402);
    rd(2'd1, d); check("R3 disabled", d, 16'h0402);
    check("R10 none enabled", vec_byte, 0);
    idle(1); check("R6 disabled no irq", irq, 0);
    wr(2'd0, 16'h0400);
    check("R10 masked", vec_byte, 8'd40);
    cleanup();

    // R10 pattern sweep
    lfsr = 14'h1ACE;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[12:0], lfsr[13] ^ lfsr[12] ^ lfsr[11] ^ lfsr[1]};
      pat = lfsr;
      ena = {lfsr[6:0], lfsr[13:7]} | 14'(k);
      wr(2'd0, 16'(ena));
      pulse(pat);
      check("R10 sweep", vec_byte, exp_vec(pat & ena));
      rd(2'd3, d); check("R10 reg", d[15:8], exp_vec(pat & ena));
      cleanup();
    end
    wr(2'd0, 16'h3FFF);

    // R5 set wins over clear
    pulse(14'h0004);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0004; src_pulse = 14'h0004;
    @(negedge clk);
    reg_we = 1'b0; src_pulse = '0;
    rd(2'd1, d); check("R5", d, 16'h0004);
    cleanup();

    // R8: clear main first, then clear one request, another re-fires
    pulse(14'h0028);
    idle(1); check("R8 setup", irq, 1);
    wr(2'd2, 16'h0000); check("R8 main cleared", irq, 0);
    wr(2'd1, 16'h0008);
    check("R8 before edge", irq, 0);
    idle(1); check("R8 rearmed", irq, 1);
    check("R8 vec", vec_byte, 8'd20);

    // R9: main still set when request cleared -> event merged and lost
    pulse(14'h0080);
    wr(2'd1, 16'h0020);
    idle(1); check("R9 merged", irq, 1);
    wr(2'd2, 16'h0000);
    idle(3); check("R9 lost", irq, 0);
    rd(2'd1, d); check("R9 still pending", d, 16'h0080);
    cleanup();

    // R11, R12 fetch path
    pulse(14'h0200);
    wr(2'd3, 16'h0001);
    rd(2'd3, d); check("R11 cfg", d, 16'h2401);
    code_addr = 16'h0055; code_mem_data = 8'hAB; #1;
    check("R11 substitute", code_data, 8'h24);
    for (int a = 16'h0050; a < 16'h005A; a++) begin
      if (a == 16'h0055) continue;
      code_addr = 16'(a); code_mem_data = 8'(a ^ 8'h5C); #1;
      check("R12 other addr", code_data, 8'(a ^ 8'h5C));
    end
    code_addr = 16'h0053; code_mem_data = 8'h02; #1;
    check("R12 opcode", code_data, 8'h02);
    code_addr = 16'h1055; code_mem_data = 8'h3C; #1;
    check("R12 alias", code_data, 8'h3C);
    wr(2'd3, 16'h0000);
    code_addr = 16'h0055; code_mem_data = 8'hAB; #1;
    check("R12 disabled", code_data, 8'hAB);
    cleanup();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule